// File: doc/BRIEF.md
# Keyed Lockable Watchdog Timer

This block is a byte-programmed watchdog. Firmware loads a 16-bit timeout as a high byte and a low byte. Writing the low byte starts the count. The counter then steps down once per slow tick. If firmware does not restart it in time by writing a fixed key value, the block raises a one-cycle reset pulse. A configuration register gates the other registers behind a lock. It also turns key matching on or off and connects the tick to the counter.

A control register decides whether the watchdog can be halted. Cleared, it makes a running watchdog impossible to stop. A timer-1 start register must be written before the count advances, because the watchdog tick only runs once that timer is started.

A separate warning timer counts its own tick. It raises an interrupt a fixed number of ticks after each restart, so firmware can capture state before the watchdog fires. The prescaler dividers are outside the block: both ticks arrive as one-cycle enable pulses.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the reset pulse and the warning interrupt are low, the live count reads 0x0000, and the configuration and control registers read 0x00.
- R2: Writing the low-byte count register loads the counter with {stored high byte, written low byte}, captures that value as the reload value, and starts the watchdog running. The count is readable on the next cycle.
- R3: The counter decreases by exactly one on each watchdog tick, and only when three things hold: it is running, timer 1 has been started, and configuration bit 4 (tick select) is 1. When bit 4 is 0, ticks leave the count unchanged.
- R4: A tick that takes the count from 1 (or 0) to zero drives the reset output high for exactly one cycle, starting on the cycle after that tick. The counter then holds 0 and ignores ticks until the low byte is written again.
- R5: A key register write of 0x5C while configuration bit 5 (key enable) is 1 and the watchdog is running reloads the captured value. Any other key value, or any key write while bit 5 is 0, leaves the count unchanged.
- R6: The block is locked when the configuration register's bits 3:0 are all 1 (for example after writing 0x3F). While locked, writes to control, count high, count low and timer-1 start are ignored. A configuration write is also ignored unless its value is 0x00, which unlocks the block and clears the register.
- R7: The key register stays writable while the block is locked.
- R8: Control bit 0 enables stopping and bit 1 requests a halt. The count freezes only while both are 1. While the watchdog runs with bit 0 clear, writes to the control register are ignored.
- R9: Writing 0x03 to the warning control register loads the warning timer with WARN_TICKS and clears the interrupt. The interrupt rises on the cycle after the WARN_TICKS-th warning tick and stays high until the next restart. WARN_TICKS must be set below the programmed watchdog period.
- R10: A warning control write of any value other than 0x03 leaves the warning timer and interrupt unchanged.
- R11: The address map is: 0 configuration, 1 control, 2 count high, 3 count low, 4 key, 5 timer-1 start, 6 warning control. Reads of 2 and 3 return the bytes of the live count. A read of 5 returns the timer-1 running flag in bit 0. A read of 6 returns the interrupt pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_tick | input | 1 | Watchdog count enable pulse |
| warn_tick | input | 1 | Warning timer count enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| wdt_reset_o | output | 1 | One-cycle watchdog reset pulse |
| warn_irq_o | output | 1 | Warning interrupt, held until restarted |

## Verification
A wrong lock, key or halt state shows at the ports within one cycle of the write it should have gated. The live count read back at addresses 2 and 3 then differs from the value the bench computes, either in the count itself or in its later ticks. A wrong counter or expiry state shows as a missing, early or doubled reset pulse on the cycle after the final tick. A warning timer fault shows as an interrupt that rises one tick early or late, or one that drops without a 0x03 restart.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [BYTE_W-1:0] KEY_MAGIC    = 8'h5C;
    localparam logic [BYTE_W-1:0] WARN_RESTART = 8'h03;
    localparam logic [BYTE_W-1:0] CFG_UNLOCK   = 8'h00;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG   = 3'd0,
        A_CTRL  = 3'd1,
        A_CNTHI = 3'd2,
        A_CNTLO = 3'd3,
        A_KEY   = 3'd4,
        A_T1GO  = 3'd5,
        A_WARN  = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] spare;
        logic       key_en;
        logic       tick_sel;
        logic [3:0] lock_f;
    } cfg_t;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       halt;
        logic       stop_en;
    } ctrl_t;

    function automatic logic cfg_locked(input cfg_t c);
        return &c.lock_f;
    endfunction

    function automatic logic ctrl_frozen(input ctrl_t c);
        return c.stop_en & c.halt;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]    live_count,
    input  logic                wd_running,
    input  logic                warn_pend,
    input  logic                warn_run,
    output cfg_t                cfg_q,
    output ctrl_t               ctrl_q,
    output logic                t1_run_q,
    output logic                load_p,
    output logic [CNT_W-1:0]    load_val,
    output logic                kick_p,
    output logic [CNT_W-1:0]    reload_val,
    output logic                warn_restart_p
);

    localparam int HI_W = CNT_W - BYTE_W;

    reg_addr_e        addr_e;
    logic             locked;
    logic             wr_cfg, wr_ctrl, wr_hi, wr_lo, wr_key, wr_t1, wr_warn;
    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] prog_q;

    assign addr_e = reg_addr_e'(bus_addr);
    assign locked = cfg_locked(cfg_q);

    always_comb begin
        wr_cfg  = 1'b0;
        wr_ctrl = 1'b0;
        wr_hi   = 1'b0;
        wr_lo   = 1'b0;
        wr_key  = 1'b0;
        wr_t1   = 1'b0;
        wr_warn = 1'b0;
        if (bus_wr) begin
            unique case (addr_e)
                A_CFG:   wr_cfg  = !locked || (bus_wdata == CFG_UNLOCK);
                A_CTRL:  wr_ctrl = !locked && !(wd_running && !ctrl_q.stop_en);
                A_CNTHI: wr_hi   = !locked;
                A_CNTLO: wr_lo   = !locked;
                A_KEY:   wr_key  = 1'b1;
                A_T1GO:  wr_t1   = !locked;
                A_WARN:  wr_warn = 1'b1;
                default: ;
            endcase
        end
    end

    assign load_p         = wr_lo;
    assign load_val       = {hi_q, bus_wdata};
    assign kick_p         = wr_key && cfg_q.key_en && (bus_wdata == KEY_MAGIC);
    assign reload_val     = prog_q;
    assign warn_restart_p = wr_warn && (bus_wdata == WARN_RESTART);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            ctrl_q   <= '0;
            hi_q     <= '0;
            prog_q   <= '0;
            t1_run_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q    <= cfg_t'(bus_wdata);
            if (wr_ctrl) ctrl_q   <= ctrl_t'(bus_wdata);
            if (wr_hi)   hi_q     <= bus_wdata[HI_W-1:0];
            if (wr_lo)   prog_q   <= {hi_q, bus_wdata};
            if (wr_t1)   t1_run_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr_e)
            A_CFG:   bus_rdata = cfg_q;
            A_CTRL:  bus_rdata = ctrl_q;
            A_CNTHI: bus_rdata = BYTE_W'(live_count[CNT_W-1:BYTE_W]);
            A_CNTLO: bus_rdata = live_count[BYTE_W-1:0];
            A_T1GO:  bus_rdata = {{(BYTE_W-1){1'b0}}, t1_run_q};
            A_WARN:  bus_rdata = {{(BYTE_W-2){1'b0}}, warn_run, warn_pend};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_p,
    input  logic [CNT_W-1:0] load_val,
    input  logic             kick_p,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             step_en,
    output logic [CNT_W-1:0] count_q,
    output logic             running_q,
    output logic             expire_q
);

    logic last_step;

    assign last_step = step_en && running_q && !load_p && !kick_p &&
                       (count_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
            expire_q  <= 1'b0;
        end else begin
            expire_q <= last_step;
            if (load_p) begin
                count_q   <= load_val;
                running_q <= 1'b1;
            end else if (kick_p && running_q) begin
                count_q <= reload_val;
            end else if (last_step) begin
                count_q   <= '0;
                running_q <= 1'b0;
            end else if (step_en && running_q) begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/kwdt_warn.sv
module kwdt_warn #(
    parameter int WARN_W     = 8,
    parameter int WARN_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_p,
    input  logic tick,
    output logic pend_q,
    output logic run_q
);

    logic [WARN_W-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (restart_p) begin
            wcnt_q <= WARN_W'(WARN_TICKS);
            pend_q <= 1'b0;
            run_q  <= 1'b1;
        end else if (tick && run_q) begin
            if (wcnt_q <= WARN_W'(1)) begin
                wcnt_q <= '0;
                pend_q <= 1'b1;
                run_q  <= 1'b0;
            end else begin
                wcnt_q <= wcnt_q - WARN_W'(1);
            end
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int WARN_W     = 8,
    parameter int WARN_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wd_tick,
    input  logic        warn_tick,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        wdt_reset_o,
    output logic        warn_irq_o
);

    cfg_t             cfg_q;
    ctrl_t            ctrl_q;
    logic             t1_run_q;
    logic             load_p, kick_p, warn_restart_p;
    logic [CNT_W-1:0] load_val, reload_val, count_q;
    logic             running_q, expire_q;
    logic             warn_pend, warn_run;
    logic             step_en;
    logic             locked;

    assign locked  = cfg_locked(cfg_q);
    assign step_en = wd_tick && t1_run_q && cfg_q.tick_sel && !ctrl_frozen(ctrl_q);

    kwdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .live_count     (count_q),
        .wd_running     (running_q),
        .warn_pend      (warn_pend),
        .warn_run       (warn_run),
        .cfg_q          (cfg_q),
        .ctrl_q         (ctrl_q),
        .t1_run_q       (t1_run_q),
        .load_p         (load_p),
        .load_val       (load_val),
        .kick_p         (kick_p),
        .reload_val     (reload_val),
        .warn_restart_p (warn_restart_p)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_p     (load_p),
        .load_val   (load_val),
        .kick_p     (kick_p),
        .reload_val (reload_val),
        .step_en    (step_en),
        .count_q    (count_q),
        .running_q  (running_q),
        .expire_q   (expire_q)
    );

    kwdt_warn #(.WARN_W(WARN_W), .WARN_TICKS(WARN_TICKS)) u_warn (
        .clk       (clk),
        .rst       (rst),
        .restart_p (warn_restart_p),
        .tick      (warn_tick),
        .pend_q    (warn_pend),
        .run_q     (warn_run)
    );

    assign wdt_reset_o = expire_q;
    assign warn_irq_o  = warn_pend;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             wdt_reset_o,
    input logic             warn_irq_o,
    input logic [CNT_W-1:0] count_q,
    input logic             running_q,
    input logic             load_p,
    input logic             kick_p,
    input logic             locked,
    input logic [7:0]       ctrl_bits
);

    // R4
    reset_single_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |=> !wdt_reset_o);

    // R4
    reset_halts_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |-> (!running_q && count_q == '0) || $past(load_p));

    // R3
    no_count_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_p && !kick_p) |=> count_q <= $past(count_q));

    // R6
    locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && bus_wr && bus_addr == 3'd1) |=> $stable(ctrl_bits));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (warn_irq_o && !(bus_wr && bus_addr == 3'd6 && bus_wdata == 8'h03))
        |=> warn_irq_o);

    // R5
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd4 && bus_wdata != 8'h5C) |-> !kick_p);

endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wdt_reset_o (wdt_reset_o),
    .warn_irq_o  (warn_irq_o),
    .count_q     (count_q),
    .running_q   (running_q),
    .load_p      (load_p),
    .kick_p      (kick_p),
    .locked      (locked),
    .ctrl_bits   (ctrl_q)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;

    localparam int WT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_tick = 1'b0;
    logic       warn_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd7;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_reset_o;
    logic       warn_irq_o;

    int checks = 0;
    int failures = 0;
    logic watchdog_hit = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt #(.CNT_W(16), .WARN_W(8), .WARN_TICKS(WT)) uut (
        .clk(clk), .rst(rst), .wd_tick(wd_tick), .warn_tick(warn_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_reset_o(wdt_reset_o), .warn_irq_o(warn_irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd7;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 3'd7;
    endtask

    task automatic rd_count(output logic [15:0] c);
        logic [7:0] h, l;
        rd(3'd2, h);
        rd(3'd3, l);
        c = {h, l};
    endtask

    task automatic wd_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wd_tick = 1'b1;
            @(negedge clk); wd_tick = 1'b0;
        end
    endtask

    task automatic wn_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); warn_tick = 1'b1;
            @(negedge clk); warn_tick = 1'b0;
        end
    endtask

    task automatic arm(input logic [7:0] hi, input logic [7:0] lo);
        wr(3'd0, 8'h30);
        wr(3'd5, 8'h00);
        wr(3'd2, hi);
        wr(3'd3, lo);
    endtask

    task automatic t_reset();
        logic [15:0] c; logic [7:0] d;
        do_reset();
        check("R1 reset pulse", {15'd0, wdt_reset_o}, 16'd0);
        check("R1 irq", {15'd0, warn_irq_o}, 16'd0);
        rd_count(c); check("R1 count", c, 16'h0000);
        rd(3'd0, d); check("R1 cfg", {8'd0, d}, 16'h0000);
        rd(3'd1, d); check("R1 ctrl", {8'd0, d}, 16'h0000);
    endtask

    task automatic t_load_count();
        logic [15:0] c; logic [7:0] d;
        do_reset();
        arm(8'h01, 8'h05);
        rd_count(c); check("R2 load", c, 16'h0105);
        rd(3'd5, d); check("R11 t1 flag", {8'd0, d}, 16'h0001);
        wr(3'd2, 8'h77);
        rd_count(c); check("R2 high alone no load", c, 16'h0105);
        wd_ticks(3);
        rd_count(c); check("R3 decrement", c, 16'h0102);
        wr(3'd0, 8'h20);
        wd_ticks(2);
        rd_count(c); check("R3 tick_sel off", c, 16'h0102);
        do_reset();
        wr(3'd0, 8'h30); wr(3'd2, 8'h00); wr(3'd3, 8'h09);
        wd_ticks(2);
        rd_count(c); check("R3 timer1 not started", c, 16'h0009);
    endtask

    task automatic t_expire();
        logic [15:0] c;
        do_reset();
        arm(8'h00, 8'h03);
        wd_ticks(2);
        check("R4 no early pulse", {15'd0, wdt_reset_o}, 16'd0);
        wd_ticks(1);
        check("R4 pulse high", {15'd0, wdt_reset_o}, 16'd1);
        @(negedge clk);
        check("R4 pulse one cycle", {15'd0, wdt_reset_o}, 16'd0);
        wd_ticks(3);
        check("R4 no repeat pulse", {15'd0, wdt_reset_o}, 16'd0);
        rd_count(c); check("R4 held zero", c, 16'h0000);
        wr(3'd4, 8'h5C);
        rd_count(c); check("R4 key after expiry", c, 16'h0000);
        wr(3'd3, 8'h04);
        wd_ticks(1);
        rd_count(c); check("R4 restart by low write", c, 16'h0003);
    endtask

    task automatic t_key();
        logic [15:0] c;
        do_reset();
        arm(8'h00, 8'h10);
        wd_ticks(4);
        wr(3'd4, 8'h12);
        rd_count(c); check("R5 wrong key", c, 16'h000C);
        wr(3'd4, 8'h5C);
        rd_count(c); check("R5 magic key reload", c, 16'h0010);
        wr(3'd0, 8'h10);
        wd_ticks(2);
        wr(3'd4, 8'h5C);
        rd_count(c); check("R5 key disabled", c, 16'h000E);
    endtask

    task automatic t_lock();
        logic [15:0] c; logic [7:0] d;
        do_reset();
        arm(8'h00, 8'h20);
        wr(3'd0, 8'h3F);
        wr(3'd2, 8'h99); wr(3'd3, 8'h99);
        rd_count(c); check("R6 locked count write", c, 16'h0020);
        wr(3'd1, 8'h03);
        rd(3'd1, d); check("R6 locked ctrl write", {8'd0, d}, 16'h0000);
        wr(3'd0, 8'h30);
        rd(3'd0, d); check("R6 locked cfg write", {8'd0, d}, 16'h003F);
        wd_ticks(5);
        wr(3'd4, 8'h5C);
        rd_count(c); check("R7 key while locked", c, 16'h0020);
        wr(3'd0, 8'h00);
        rd(3'd0, d); check("R6 unlock", {8'd0, d}, 16'h0000);
        wr(3'd0, 8'h30); wr(3'd3, 8'h07);
        rd_count(c); check("R6 write after unlock", c, 16'h0007);
    endtask

    task automatic t_ctrl();
        logic [15:0] c; logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h03);
        arm(8'h00, 8'h20);
        wd_ticks(3);
        rd_count(c); check("R8 halted", c, 16'h0020);
        wr(3'd1, 8'h01);
        wd_ticks(2);
        rd_count(c); check("R8 resumed", c, 16'h001E);
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h03);
        rd(3'd1, d); check("R8 non-stoppable ctrl", {8'd0, d}, 16'h0000);
        wd_ticks(2);
        rd_count(c); check("R8 keeps counting", c, 16'h001C);
    endtask

    task automatic t_warn();
        logic [7:0] d;
        do_reset();
        wr(3'd6, 8'h03);
        wn_ticks(WT - 1);
        check("R9 not yet", {15'd0, warn_irq_o}, 16'd0);
        wn_ticks(1);
        check("R9 irq rises", {15'd0, warn_irq_o}, 16'd1);
        rd(3'd6, d); check("R11 irq readback", {15'd0, d[0]}, 16'd1);
        wn_ticks(3);
        check("R9 irq held", {15'd0, warn_irq_o}, 16'd1);
        wr(3'd6, 8'h07);
        check("R10 other value", {15'd0, warn_irq_o}, 16'd1);
        wr(3'd6, 8'h03);
        check("R9 cleared", {15'd0, warn_irq_o}, 16'd0);
        wn_ticks(3);
        wr(3'd6, 8'h01);
        wn_ticks(WT - 4);
        check("R10 no reload", {15'd0, warn_irq_o}, 16'd0);
        wn_ticks(1);
        check("R10 irq at original time", {15'd0, warn_irq_o}, 16'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_count();
                t_expire();
                t_key();
                t_lock();
                t_ctrl();
                t_warn();
            end
            begin
                repeat (20000) @(posedge clk);
                watchdog_hit = 1'b1;
            end
        join_any
        disable fork;
        if (watchdog_hit) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule